// File: doc/BRIEF.md
# Two-Wire Bus Master Write Controller

This block is a command-driven master for a two-wire serial bus (clock line and data line, both open drain) that performs write transfers only. Software loads commands into a two-slot queue: the current slot, which the bit sequencer works from, and a next slot that moves up when the current one retires or is discarded. Each command carries a start flag, a stop flag, a read/write flag, a 7-bit target address and a byte count. Data bytes arrive through a one-byte holding register loaded with a valid/ready handshake. While the count is nonzero and the register is empty, the master holds the clock line low.

Six status flags report the block's state, and one interrupt line combines them through an enable mask. When an address NACK, a data NACK or a lost arbitration occurs, the matching flag is set and stays set until software clears it. While any of these flags is set, no transfer starts. After a NACK the master sends STOP without being told to, and the command stays in the current slot. A byte already waiting in the holding register stays there and goes out as the first data byte of the next transfer. Bus timing comes from a fixed clock divider parameter: each bus bit lasts four divider ticks.

Top module: `twowire_wr_master`

## Requirements
- R1: After reset, both line drivers are released (`scl_oe`=`sda_oe`=0), `irq` is 0, and `status` reads 6'b000111 when both lines are high. Whenever status bit 0 is set, both drivers are released.
- R2: A transfer begins only when all of these hold: the engine is idle, both lines are sampled high, the current command is valid with start=1 and read=0, and no error flag is set. A command with read=1 never starts. The master sends START (the data line falls while the clock line is high), then the address byte `{addr[6:0],1'b0}`, MSB first.
- R3: On the ninth clock of the address byte the master releases the data line and samples it. If the line is high, status bit 3 (address NACK) is set.
- R4: For each data byte while the count is nonzero, the master waits for the holding register to be full and holds the clock line low while it waits. It then sends the byte MSB first, and the count drops by one.
- R5: When the count is zero and the stop flag is set, the master sends STOP (the data line rises while the clock line is high). A command with start=1, stop=1 and count=0 produces only START, the address byte and STOP.
- R6: After an address NACK or a data NACK (status bit 4), the master sends STOP on its own and the current command stays valid. Clearing the flag then runs the same command again.
- R7: Status bits 3, 4 and 5 stay set until their `err_clr` bit (bit 0, 1 and 2 respectively) is pulsed. While any of them is set, no transfer starts.
- R8: Pulsing `cur_drop` discards the current command, and a pending next command moves into the current slot.
- R9: A byte in the holding register when a NACK occurs stays there and is sent as the first data byte of the following transfer.
- R10: If the master releases the data line for a 1 bit but samples it low, it releases both lines, sets status bit 5 (arbitration lost) and returns to idle.
- R11: Status bit 0 is set when the engine is idle and both lines are high. Bit 1 is set when a command slot is empty. Bit 2 is set when the holding register is empty. A write goes to the current slot if that slot is empty, otherwise to the next slot, and is dropped when both slots are full.
- R12: `irq` is the OR of `status & mask`. `irq_en_set` sets mask bits, `irq_en_clr` clears them, and the clear wins when both strobes hit the same bit.
- R13: A command with stop=0 retires after its last byte and leaves the clock line held low. If the next command has start=1, it begins with a repeated START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_start | input | 1 | Command start flag |
| cmd_stop | input | 1 | Command stop flag |
| cmd_read | input | 1 | Command read flag (1 = read, never started) |
| cmd_addr | input | 7 | Target address |
| cmd_count | input | 8 | Number of data bytes |
| cur_drop | input | 1 | Discard the current command |
| tx_data | input | 8 | Byte for the holding register |
| tx_valid | input | 1 | Holding register load request |
| tx_ready | output | 1 | Holding register empty |
| err_clr | input | 3 | Clear strobes: [0] addr NACK, [1] data NACK, [2] arbitration |
| irq_en_set | input | 6 | Interrupt mask set strobes |
| irq_en_clr | input | 6 | Interrupt mask clear strobes |
| scl_i | input | 1 | Sampled clock line |
| sda_i | input | 1 | Sampled data line |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |
| status | output | 6 | [0] bus free, [1] cmd ready, [2] tx ready, [3] addr NACK, [4] data NACK, [5] arb lost |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `scl_i` follows the master's own clock driver, since no other device stretches the clock. They also assume that the data line changes only while the clock line is low, with one exception: the deliberate pull-down used to cause an arbitration loss. All strobes are taken as single-cycle pulses applied when the engine is not racing them. The bench's target model drives the data line only in acknowledge slots, which it finds by counting clock edges after each START. It pulls the data line outside those slots only in the arbitration scenario, and it pulses every strobe for exactly one cycle, driven on the falling edge.

// File: rtl/twm_pkg.sv
package twm_pkg;
  parameter int TWM_CNT_W = 8;

  localparam int SB_FREE = 0;
  localparam int SB_CRDY = 1;
  localparam int SB_TRDY = 2;
  localparam int SB_ANAK = 3;
  localparam int SB_DNAK = 4;
  localparam int SB_ARB  = 5;
  localparam int SB_N    = 6;

  typedef struct packed {
    logic                 start;
    logic                 stop;
    logic                 rd;
    logic [6:0]           addr;
    logic [TWM_CNT_W-1:0] count;
  } twm_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_WAIT, ST_DATA, ST_STOP, ST_HOLD
  } twm_state_e;

  function automatic logic [7:0] addr_byte(input logic [6:0] a);
    return {a, 1'b0};
  endfunction

  function automatic logic [SB_N-1:0] mask_next(input logic [SB_N-1:0] m,
                                                input logic [SB_N-1:0] s,
                                                input logic [SB_N-1:0] c);
    return (m | s) & ~c;
  endfunction
endpackage

// File: rtl/twm_cmd_queue.sv
module twm_cmd_queue
  import twm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  twm_cmd_t wr_cmd,
  input  logic     drop,
  input  logic     retire,
  output twm_cmd_t cur,
  output logic     cur_vld,
  output logic     cmd_rdy
);
  twm_cmd_t cur_q, nxt_q, cur_d, nxt_d;
  logic     cur_v, nxt_v, cur_vd, nxt_vd;

  always_comb begin
    cur_d  = cur_q;
    nxt_d  = nxt_q;
    cur_vd = cur_v;
    nxt_vd = nxt_v;
    if (drop || retire) begin
      cur_d  = nxt_q;
      cur_vd = nxt_v;
      nxt_vd = 1'b0;
    end
    if (wr) begin
      if (!cur_vd) begin
        cur_d  = wr_cmd;
        cur_vd = 1'b1;
      end else if (!nxt_vd) begin
        nxt_d  = wr_cmd;
        nxt_vd = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      nxt_q <= '0;
      cur_v <= 1'b0;
      nxt_v <= 1'b0;
    end else begin
      cur_q <= cur_d;
      nxt_q <= nxt_d;
      cur_v <= cur_vd;
      nxt_v <= nxt_vd;
    end
  end

  assign cur     = cur_q;
  assign cur_vld = cur_v;
  assign cmd_rdy = !cur_v || !nxt_v;
endmodule

// File: rtl/twm_bit_engine.sv
module twm_bit_engine
  import twm_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  twm_cmd_t   cur,
  input  logic       cur_vld,
  input  logic       err_any,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       hold_full,
  input  logic [7:0] hold_byte,
  output logic       hold_take,
  output logic       retire,
  output logic       anak_set,
  output logic       dnak_set,
  output logic       arb_set,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       idle,
  output logic       xfer_begin,
  output logic       wait_tx
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

  twm_state_e           st;
  logic [1:0]           ph;
  logic [3:0]           bc;
  logic [7:0]           sh;
  logic [TWM_CNT_W-1:0] left;
  logic                 stop_q, nack_q, err_stop_q;
  logic [DW-1:0]        div_q;
  logic                 tick, bit_st, samp, nack_now, end_byte, stop_done;
  logic                 can_start, cont;

  always_ff @(posedge clk) begin
    if (!rst_n || tick) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end
  assign tick = (div_q == DW'(DIV - 1));

  assign can_start  = cur_vld && cur.start && !cur.rd && !err_any;
  assign xfer_begin = can_start && ((st == ST_IDLE && scl_i && sda_i) || st == ST_HOLD);
  assign cont       = (st == ST_HOLD) && cur_vld && !cur.start && !cur.rd && !err_any;
  assign bit_st     = (st == ST_ADDR) || (st == ST_DATA);
  assign samp       = tick && bit_st && (ph == 2'd2);
  assign arb_set    = samp && (bc != 4'd8) && !sda_oe && !sda_i;
  assign nack_now   = samp && (bc == 4'd8) && sda_i;
  assign anak_set   = nack_now && (st == ST_ADDR);
  assign dnak_set   = nack_now && (st == ST_DATA);
  assign end_byte   = tick && bit_st && (ph == 2'd3) && (bc == 4'd8);
  assign stop_done  = tick && (st == ST_STOP) && (ph == 2'd3);
  assign hold_take  = (st == ST_WAIT) && hold_full;
  assign retire     = (end_byte && !nack_q && left == '0 && !stop_q)
                    || (stop_done && !err_stop_q)
                    || (cont && cur.count == '0 && !cur.stop);
  assign idle       = (st == ST_IDLE);
  assign wait_tx    = (st == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= '0; bc <= '0; sh <= '0; left <= '0;
      stop_q <= 1'b0; nack_q <= 1'b0; err_stop_q <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_HOLD: begin
          if (xfer_begin) begin
            st <= ST_START; ph <= '0;
            sh <= addr_byte(cur.addr);
            left <= cur.count; stop_q <= cur.stop;
          end else if (cont) begin
            left <= cur.count; stop_q <= cur.stop; err_stop_q <= 1'b0;
            if (cur.count != '0)  st <= ST_WAIT;
            else if (cur.stop) begin st <= ST_STOP; ph <= '0; end
          end
        end
        ST_START: if (tick) begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin scl_oe <= 1'b1; st <= ST_ADDR; bc <= '0; end
          endcase
        end
        ST_ADDR, ST_DATA: if (tick) begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0: sda_oe <= (bc == 4'd8) ? 1'b0 : !sh[7];
            2'd1: scl_oe <= 1'b0;
            2'd2: begin
              if (arb_set) begin
                st <= ST_IDLE; ph <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0;
              end
              if (bc == 4'd8) nack_q <= sda_i;
            end
            default: begin
              scl_oe <= 1'b1;
              sh     <= {sh[6:0], 1'b0};
              if (bc == 4'd8) begin
                bc <= '0;
                if (nack_q) begin
                  st <= ST_STOP; err_stop_q <= 1'b1;
                end else if (left == '0) begin
                  err_stop_q <= 1'b0;
                  st <= stop_q ? ST_STOP : ST_HOLD;
                end else begin
                  st <= ST_WAIT;
                end
              end else begin
                bc <= bc + 1'b1;
              end
            end
          endcase
        end
        ST_WAIT: if (hold_take) begin
          sh <= hold_byte; left <= left - TWM_CNT_W'(1);
          st <= ST_DATA; ph <= '0; bc <= '0;
        end
        ST_STOP: if (tick) begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: st <= ST_IDLE;
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twm_status_irq.sv
module twm_status_irq
  import twm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            cmd_rdy,
  input  logic            hold_full,
  input  logic            anak_set,
  input  logic            dnak_set,
  input  logic            arb_set,
  input  logic [2:0]      err_clr,
  input  logic [SB_N-1:0] en_set,
  input  logic [SB_N-1:0] en_clr,
  output logic [SB_N-1:0] status,
  output logic            err_any,
  output logic            irq
);
  logic [2:0]      err_q;
  logic [2:0]      err_set;
  logic [SB_N-1:0] mask_q;

  assign err_set = {arb_set, dnak_set, anak_set};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= '0;
      mask_q <= '0;
    end else begin
      err_q  <= (err_q & ~err_clr) | err_set;
      mask_q <= mask_next(mask_q, en_set, en_clr);
    end
  end

  assign status[SB_FREE] = idle && scl_i && sda_i;
  assign status[SB_CRDY] = cmd_rdy;
  assign status[SB_TRDY] = !hold_full;
  assign status[SB_ARB:SB_ANAK] = err_q;
  assign err_any = |err_q;
  assign irq     = |(status & mask_q);
endmodule

// File: rtl/twowire_wr_master.sv
module twowire_wr_master
  import twm_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_wr,
  input  logic                 cmd_start,
  input  logic                 cmd_stop,
  input  logic                 cmd_read,
  input  logic [6:0]           cmd_addr,
  input  logic [TWM_CNT_W-1:0] cmd_count,
  input  logic                 cur_drop,
  input  logic [7:0]           tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [2:0]           err_clr,
  input  logic [SB_N-1:0]      irq_en_set,
  input  logic [SB_N-1:0]      irq_en_clr,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 scl_oe,
  output logic                 sda_oe,
  output logic [SB_N-1:0]      status,
  output logic                 irq
);
  twm_cmd_t   wr_cmd, cur;
  logic       cur_vld, cmd_rdy, retire, err_any, idle;
  logic       hold_full, hold_take;
  logic [7:0] hold_byte;
  logic       anak_set, dnak_set, arb_set;
  logic       xfer_begin, wait_tx;

  assign wr_cmd = '{start: cmd_start, stop: cmd_stop, rd: cmd_read,
                    addr: cmd_addr, count: cmd_count};

  twm_cmd_queue u_queue (
    .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .wr_cmd(wr_cmd),
    .drop(cur_drop), .retire(retire),
    .cur(cur), .cur_vld(cur_vld), .cmd_rdy(cmd_rdy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_byte <= '0;
    end else if (tx_valid && tx_ready) begin
      hold_full <= 1'b1;
      hold_byte <= tx_data;
    end else if (hold_take) begin
      hold_full <= 1'b0;
    end
  end
  assign tx_ready = !hold_full;

  twm_bit_engine #(.DIV(DIV)) u_engine (
    .clk(clk), .rst_n(rst_n), .cur(cur), .cur_vld(cur_vld), .err_any(err_any),
    .scl_i(scl_i), .sda_i(sda_i), .hold_full(hold_full), .hold_byte(hold_byte),
    .hold_take(hold_take), .retire(retire), .anak_set(anak_set),
    .dnak_set(dnak_set), .arb_set(arb_set), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .idle(idle), .xfer_begin(xfer_begin), .wait_tx(wait_tx)
  );

  twm_status_irq u_status (
    .clk(clk), .rst_n(rst_n), .idle(idle), .scl_i(scl_i), .sda_i(sda_i),
    .cmd_rdy(cmd_rdy), .hold_full(hold_full), .anak_set(anak_set),
    .dnak_set(dnak_set), .arb_set(arb_set), .err_clr(err_clr),
    .en_set(irq_en_set), .en_clr(irq_en_clr),
    .status(status), .err_any(err_any), .irq(irq)
  );
endmodule

// File: rtl/twm_checker.sv
module twm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] status,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       irq,
  input logic [5:0] irq_en_clr,
  input logic [2:0] err_clr,
  input logic       xfer_begin,
  input logic       wait_tx
);
  assert_free_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (!scl_oe && !sda_oe));

  assert_no_start_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_begin |-> (status[5:3] == 3'b000));

  assert_anak_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !err_clr[0]) |=> status[3]);

  assert_wait_holds_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wait_tx |-> scl_oe);

  assert_arb_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> (!scl_oe && !sda_oe));

  assert_mask_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_clr == 6'h3f) |=> !irq);
endmodule

bind twowire_wr_master twm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq(irq), .irq_en_clr(irq_en_clr), .err_clr(err_clr),
  .xfer_begin(xfer_begin), .wait_tx(wait_tx)
);

// File: tb/tb_twowire_wr_master.sv
`timescale 1ns/1ps
module tb_twowire_wr_master;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmd_wr = 0, cmd_start = 0, cmd_stop = 0, cmd_read = 0, cur_drop = 0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_count = '0, tx_data = '0;
  logic       tx_valid = 0, tx_ready;
  logic [2:0] err_clr = '0;
  logic [5:0] irq_en_set = '0, irq_en_clr = '0, status;
  logic       scl_i, sda_i, scl_oe, sda_oe, irq;
  logic       slave_pull = 0, arb_pull = 0, arb_arm = 0, ack_addr = 1, ack_data = 1;

  int errors = 0, checks = 0;
  int nstart = 0, nstop = 0, nlog = 0, bitcnt = 0, bytei = 0;
  logic [7:0] log_b [16];
  logic [7:0] mon_sh = '0;
  logic p_scl = 1, p_sda = 1;

  always #4 clk = ~clk;

  assign scl_i = ~scl_oe;
  assign sda_i = ~(sda_oe | slave_pull | arb_pull);

  twowire_wr_master dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_read(cmd_read), .cmd_addr(cmd_addr),
    .cmd_count(cmd_count), .cur_drop(cur_drop), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .err_clr(err_clr),
    .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr), .scl_i(scl_i),
    .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe), .status(status), .irq(irq)
  );

  // target model: decodes START/STOP, collects bytes, drives acknowledge slots
  always @(negedge clk) begin
    if (p_scl && scl_i && p_sda && !sda_i) begin
      nstart++; bitcnt = 0; bytei = 0;
      if (arb_arm) arb_pull = 1;
    end else if (p_scl && scl_i && !p_sda && sda_i) begin
      nstop++;
    end else if (!p_scl && scl_i) begin
      mon_sh = {mon_sh[6:0], sda_i}; bitcnt++;
    end else if (p_scl && !scl_i) begin
      if (bitcnt == 8) begin
        slave_pull = (bytei == 0) ? ack_addr : ack_data;
        if (nlog < 16) log_b[nlog] = mon_sh;
        nlog++;
      end else if (bitcnt == 9) begin
        slave_pull = 0; bitcnt = 0; bytei++;
      end
    end
    p_scl = scl_i; p_sda = sda_i;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_log();
    nstart = 0; nstop = 0; nlog = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_cmd(input logic s, input logic p, input logic r,
                          input logic [6:0] a, input logic [7:0] c);
    cmd_start = s; cmd_stop = p; cmd_read = r; cmd_addr = a; cmd_count = c;
    cmd_wr = 1; @(negedge clk); cmd_wr = 0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    int n = 0;
    while (!tx_ready && n < 20000) begin @(negedge clk); n++; end
    tx_data = b; tx_valid = 1; @(negedge clk); tx_valid = 0;
  endtask

  task automatic pulse_drop();
    cur_drop = 1; @(negedge clk); cur_drop = 0;
  endtask

  task automatic pulse_clr(input logic [2:0] m);
    err_clr = m; @(negedge clk); err_clr = '0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    cycles(4);
    while (!status[0] && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk({tag, " idle timeout"}, 0, 1);
  endtask

  task automatic t_reset();
    cycles(2);
    chk("R1 status after reset", status, 6'b000111);
    chk("R1 lines released", {scl_oe, sda_oe}, 0);
    chk("R1 irq after reset", irq, 0);
  endtask

  task automatic t_basic();
    clr_log();
    push_byte(8'hA5);
    cycles(1);
    chk("R11 tx ready low when held", status[2], 0);
    push_cmd(1, 1, 0, 7'h2A, 8'd2);
    push_byte(8'h3C);
    wait_idle("R4 basic");
    chk("R2 starts", nstart, 1);
    chk("R2 address byte", log_b[0], 8'h54);
    chk("R4 first data", log_b[1], 8'hA5);
    chk("R4 second data", log_b[2], 8'h3C);
    chk("R5 stop sent", nstop, 1);
    chk("R11 status after write", status, 6'b000111);
    // R4: clock held low while holding register is empty
    clr_log();
    push_cmd(1, 1, 0, 7'h55, 8'd1);
    cycles(300);
    chk("R4 clock held low", scl_oe, 1);
    chk("R4 bus not free", status[0], 0);
    push_byte(8'hC3);
    wait_idle("R4 stall");
    chk("R4 byte after stall", log_b[1], 8'hC3);
    chk("R4 byte total", nlog, 2);
  endtask

  task automatic t_zero();
    clr_log();
    push_cmd(1, 1, 0, 7'h71, 8'd0);
    wait_idle("R5 zero");
    chk("R5 only address byte", nlog, 1);
    chk("R5 address value", log_b[0], 8'hE2);
    chk("R5 stop after zero", nstop, 1);
  endtask

  task automatic t_anak();
    clr_log();
    ack_addr = 0;
    push_cmd(1, 1, 0, 7'h2B, 8'd0);
    wait_idle("R3 anak");
    chk("R3 address NACK flag", status[3], 1);
    chk("R6 automatic stop", nstop, 1);
    cycles(400);
    chk("R7 no restart while flag set", nstart, 1);
    chk("R7 flag persists", status[3], 1);
    ack_addr = 1;
    clr_log();
    pulse_clr(3'b001);
    wait_idle("R6 rerun");
    chk("R6 same command rerun", nstart, 1);
    chk("R6 rerun address", log_b[0], 8'h56);
    chk("R7 flag cleared", status, 6'b000111);
  endtask

  task automatic t_dnak();
    clr_log();
    ack_data = 0;
    push_byte(8'h11);
    push_cmd(1, 1, 0, 7'h40, 8'd2);
    push_byte(8'h22);
    wait_idle("R6 dnak");
    chk("R6 data NACK flag", status[4], 1);
    chk("R6 stop after data NACK", nstop, 1);
    chk("R6 bytes before NACK", nlog, 2);
    chk("R9 byte kept", status[2], 0);
    clr_log();
    ack_data = 1;
    push_cmd(1, 1, 0, 7'h33, 8'd1);
    chk("R11 both slots full", status[1], 0);
    pulse_drop();
    pulse_clr(3'b010);
    wait_idle("R8 promoted");
    chk("R8 next command runs", log_b[0], 8'h66);
    chk("R9 carried byte first", log_b[1], 8'h22);
    chk("R8 single transfer", nstart, 1);
    chk("R8 idle status", status, 6'b000111);
  endtask

  task automatic t_arb();
    int n = 0;
    clr_log();
    arb_arm = 1;
    push_cmd(1, 1, 0, 7'h50, 8'd0);
    while (!status[5] && n < 5000) begin @(negedge clk); n++; end
    chk("R10 arbitration flag", status[5], 1);
    chk("R10 lines released", {scl_oe, sda_oe}, 0);
    arb_arm = 0; arb_pull = 0;
    cycles(40);
    chk("R10 returned idle", status[0], 1);
    pulse_drop();
    pulse_clr(3'b100);
    cycles(40);
    chk("R10 clean after clear", status, 6'b000111);
  endtask

  task automatic t_queue();
    clr_log();
    push_cmd(1, 1, 1, 7'h01, 8'd0);
    chk("R11 one slot free", status[1], 1);
    push_cmd(1, 1, 1, 7'h02, 8'd0);
    chk("R11 no slot free", status[1], 0);
    push_cmd(1, 1, 0, 7'h03, 8'd0);
    cycles(100);
    chk("R2 read command never starts", nstart, 0);
    pulse_drop();
    chk("R8 slot freed", status[1], 1);
    pulse_drop();
    cycles(100);
    chk("R11 dropped write did not run", nstart, 0);
  endtask

  task automatic t_irq();
    irq_en_set = 6'b000001; @(negedge clk); irq_en_set = '0;
    chk("R12 irq on bus free", irq, 1);
    irq_en_clr = 6'b000001; @(negedge clk); irq_en_clr = '0;
    chk("R12 irq cleared", irq, 0);
    irq_en_set = 6'b000100; irq_en_clr = 6'b000100; @(negedge clk);
    irq_en_set = '0; irq_en_clr = '0;
    chk("R12 clear wins", irq, 0);
    irq_en_set = 6'b001000; @(negedge clk); irq_en_set = '0;
    chk("R12 masked flag low", irq, 0);
    irq_en_clr = 6'h3f; @(negedge clk); irq_en_clr = '0;
  endtask

  task automatic t_rstart();
    clr_log();
    push_cmd(1, 0, 0, 7'h10, 8'd0);
    push_cmd(1, 1, 0, 7'h11, 8'd0);
    wait_idle("R13 repeated start");
    chk("R13 two starts", nstart, 2);
    chk("R13 one stop", nstop, 1);
    chk("R13 first address", log_b[0], 8'h20);
    chk("R13 second address", log_b[1], 8'h22);
  endtask

  initial begin
    fork
      begin
        cycles(5);
        rst_n = 1;
        t_reset();
        t_basic();
        t_zero();
        t_anak();
        t_dnak();
        t_arb();
        t_queue();
        t_irq();
        t_rstart();
      end
      begin
        repeat (150000) @(posedge clk);
        chk("watchdog expired", 1, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule